// File: doc/BRIEF.md
# Circular-Buffer Audio Sample Fetch Engine

This block streams audio samples out of a circular region of memory into a downstream sink such as a serial audio transmitter or a pulse-width modulator. Software programs the byte base address of the region and its length in sample words. It then raises the enable input and keeps moving a producer write index forward as it writes new samples. The block keeps its own read index. It fetches whole bursts of produced samples over a read-address / read-data channel pair that follows the AXI4 handshake rules, holds the returned beats in a small FIFO, and hands them to the sink over a valid/ready stream.

The read index runs in word steps from the start of the region and returns to zero at its end. A burst is cut short so that it ends exactly at the end of the region. When the read index equals the write index the region holds no unread data. If the sink asks for data while nothing is buffered and too little has been produced, the block sends zero samples, latches a sticky underrun flag and raises an interrupt. The region length must be larger than the maximum burst length.

Top module: `ring_stream_dma`

## Requirements
- R1: A burst's byte address is base + read index × (DATA_W/8). After each burst the read index advances by the burst's beat count, and it becomes 0 when it reaches the region length.
- R2: The beat count of a burst is the smaller of MAX_BURST and (length − read index), so no burst crosses the end of the region. The length field equals beats − 1, the size field equals log2(DATA_W/8) (1 for 16-bit samples), and the burst-type field is 2'b01 (incrementing).
- R3: A burst starts only when all of these hold: the engine is enabled and idle, the FIFO has at least MAX_BURST free entries, and the produced count ((write − read) mod length, where equal indices mean empty) is at least the beat count.
- R4: At most one burst is in flight. The read-data ready output is high only during the data phase of a burst, and the address valid output stays low from the accepted address until the beat flagged last.
- R5: Returned beats leave the sample output in arrival order. A sample leaves only when valid and ready are both high, and the head sample stays on the output while ready is low.
- R6: If the engine is enabled, the FIFO is empty, no burst is in flight and the produced count is below the beat count, sample valid is high with data 0.
- R7: The underrun flag sets in the cycle after a zero sample from R6 is accepted. It then stays set until a clear pulse arrives, and the clear is ignored in a cycle where a new zero sample is accepted.
- R8: With USE_IRQ set (the default), the interrupt output equals the underrun flag.
- R9: During an active-low reset the address valid, read-data ready, underrun and interrupt outputs are 0, the FIFO is empty and the read index is 0.
- R10: While enable is low, no burst starts and no zero samples are sent. A burst already in flight completes, after which the read index returns to 0.
- R11: Once address valid is high, it and the address and length fields stay unchanged until address ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable |
| base_i | input | ADDR_W | Byte base address of the circular region |
| size_i | input | IDX_W | Region length in sample words |
| wr_ptr_i | input | IDX_W | Producer write index, in words |
| clr_underrun_i | input | 1 | One-cycle pulse that clears the underrun flag |
| arvalid_o | output | 1 | Read address valid |
| arready_i | input | 1 | Read address ready |
| araddr_o | output | ADDR_W | Burst byte address |
| arlen_o | output | 8 | Beats minus one |
| arsize_o | output | 3 | log2 of bytes per beat |
| arburst_o | output | 2 | Burst type, incrementing |
| rvalid_i | input | 1 | Read data valid |
| rready_o | output | 1 | Read data ready |
| rdata_i | input | DATA_W | Read data beat |
| rlast_i | input | 1 | Last beat of the burst |
| sample_valid_o | output | 1 | Sample valid |
| sample_ready_i | input | 1 | Sink ready |
| sample_data_o | output | DATA_W | Sample word |
| underrun_o | output | 1 | Sticky underrun flag |
| irq_o | output | 1 | Underrun interrupt |

## Verification
The hardest case to reach is a burst shortened at the end of the region that comes right after the engine has been starved. Reaching it needs a region length that is not a multiple of the burst length, a write index placed so that fewer than a full burst of samples remain before the wrap, and then a write index that wraps past zero. The stimulus gets there by first starving the engine with a length of 22 words, and later switching, while disabled, to a length of 6 words with write indices 5 and then 3. Long stretches with the sink stalled fill the FIFO, which checks that a new burst is held back for lack of space. A behavioural reference model built on a queue checks every output on every clock.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_ADDR = 2'd1,
      FS_DATA = 2'd2
   } fetch_state_e;

   localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 8,
   localparam int PW    = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [W-1:0]     din_i,
   input  logic             pop_i,
   output logic [W-1:0]     dout_o,
   output logic             empty_o,
   output logic [CNT_W-1:0] count_o
);
   logic [W-1:0]     mem_q [DEPTH];
   logic [PW-1:0]    wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wp_q <= wp_q + 1'b1;
         if (pop_i)  rp_q <= rp_q + 1'b1;
         case ({push_i, pop_i})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (push_i) mem_q[wp_q] <= din_i;
   end

   assign dout_o  = mem_q[rp_q];
   assign empty_o = (cnt_q == '0);
   assign count_o = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i && !pop_i |-> cnt_q != CNT_W'(DEPTH)); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i |-> cnt_q != '0); // R5
endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
   import ring_dma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int IDX_W     = 12,
   parameter int MAX_BURST = 4,
   parameter int SZ_CODE   = 1,
   localparam int CW    = IDX_W + 1,
   localparam int LEN_W = $clog2(MAX_BURST + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IDX_W-1:0]  size_i,
   input  logic [IDX_W-1:0]  wr_ptr_i,
   input  logic              room_i,
   output logic              arvalid_o,
   input  logic              arready_i,
   output logic [ADDR_W-1:0] araddr_o,
   output logic [7:0]        arlen_o,
   input  logic              rvalid_i,
   input  logic              rlast_i,
   output logic              rready_o,
   output logic              idle_o,
   output logic              short_o
);
   fetch_state_e     st_q;
   logic [IDX_W-1:0] rd_q;
   logic [LEN_W-1:0] len_q, len_c;
   logic [CW-1:0]    avail, to_end, nxt;
   logic             issue;

   always_comb begin
      if (wr_ptr_i >= rd_q) avail = CW'(wr_ptr_i) - CW'(rd_q);
      else                  avail = CW'(wr_ptr_i) + CW'(size_i) - CW'(rd_q);
      to_end  = CW'(size_i) - CW'(rd_q);
      len_c   = (to_end < CW'(MAX_BURST)) ? LEN_W'(to_end) : LEN_W'(MAX_BURST);
      short_o = avail < CW'(len_c);
      nxt     = CW'(rd_q) + CW'(len_q);
      issue   = enable_i && (st_q == FS_IDLE) && room_i && !short_o && (len_c != '0);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= FS_IDLE;
         rd_q  <= '0;
         len_q <= '0;
      end else begin
         case (st_q)
            FS_IDLE: begin
               if (issue) begin
                  st_q  <= FS_ADDR;
                  len_q <= len_c;
               end else if (!enable_i) begin
                  rd_q <= '0;
               end
            end
            FS_ADDR: begin
               if (arready_i) begin
                  st_q <= FS_DATA;
                  rd_q <= (nxt >= CW'(size_i)) ? '0 : nxt[IDX_W-1:0];
               end
            end
            FS_DATA: begin
               if (rvalid_i && rlast_i) st_q <= FS_IDLE;
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assign arvalid_o = (st_q == FS_ADDR);
   assign araddr_o  = base_i + (ADDR_W'(rd_q) << SZ_CODE);
   assign arlen_o   = 8'(len_q) - 8'd1;
   assign rready_o  = (st_q == FS_DATA);
   assign idle_o    = (st_q == FS_IDLE);

   AST_AR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arvalid_o && !arready_i |=> arvalid_o && $stable(araddr_o) && $stable(arlen_o)); // R11
   AST_BURST_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arvalid_o |-> CW'(rd_q) + CW'(arlen_o) + 1 <= CW'(size_i)); // R2
endmodule

// File: rtl/ring_stream_dma.sv
module ring_stream_dma
   import ring_dma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 16,
   parameter int IDX_W      = 12,
   parameter int MAX_BURST  = 4,
   parameter int FIFO_DEPTH = 8,
   parameter bit USE_IRQ    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IDX_W-1:0]  size_i,
   input  logic [IDX_W-1:0]  wr_ptr_i,
   input  logic              clr_underrun_i,
   output logic              arvalid_o,
   input  logic              arready_i,
   output logic [ADDR_W-1:0] araddr_o,
   output logic [7:0]        arlen_o,
   output logic [2:0]        arsize_o,
   output logic [1:0]        arburst_o,
   input  logic              rvalid_i,
   output logic              rready_o,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              rlast_i,
   output logic              sample_valid_o,
   input  logic              sample_ready_i,
   output logic [DATA_W-1:0] sample_data_o,
   output logic              underrun_o,
   output logic              irq_o
);
   localparam int BYTES   = DATA_W / 8;
   localparam int SZ_CODE = $clog2(BYTES);
   localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

   if (DATA_W % 8 != 0 || (1 << SZ_CODE) != BYTES) begin : g_bad_width
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (MAX_BURST < 1 || MAX_BURST > 256) begin : g_bad_burst
      $error("MAX_BURST must lie in 1..256");
   end
   if (FIFO_DEPTH < MAX_BURST || (1 << $clog2(FIFO_DEPTH)) != FIFO_DEPTH) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two no smaller than MAX_BURST");
   end

   logic              room, idle, short_c, f_empty, push, pop, starve, flag_q;
   logic [CNT_W-1:0]  f_count;
   logic [DATA_W-1:0] f_dout;

   assign room = (f_count <= CNT_W'(FIFO_DEPTH - MAX_BURST));

   ring_fetch_ctrl #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MAX_BURST(MAX_BURST), .SZ_CODE(SZ_CODE)
   ) u_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .base_i(base_i),
      .size_i(size_i), .wr_ptr_i(wr_ptr_i), .room_i(room),
      .arvalid_o(arvalid_o), .arready_i(arready_i), .araddr_o(araddr_o),
      .arlen_o(arlen_o), .rvalid_i(rvalid_i), .rlast_i(rlast_i),
      .rready_o(rready_o), .idle_o(idle), .short_o(short_c)
   );

   assign push = rvalid_i && rready_o;
   assign pop  = !f_empty && sample_ready_i;

   sample_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .din_i(rdata_i),
      .pop_i(pop), .dout_o(f_dout), .empty_o(f_empty), .count_o(f_count)
   );

   assign arsize_o  = 3'(SZ_CODE);
   assign arburst_o = BURST_INCR;

   assign starve         = enable_i && f_empty && idle && short_c;
   assign sample_valid_o = !f_empty || starve;
   assign sample_data_o  = f_empty ? '0 : f_dout;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        flag_q <= 1'b0;
      else if (starve && sample_ready_i)  flag_q <= 1'b1;
      else if (clr_underrun_i)            flag_q <= 1'b0;
   end
   assign underrun_o = flag_q;

   if (USE_IRQ) begin : g_irq
      assign irq_o = flag_q;
   end else begin : g_no_irq
      assign irq_o = 1'b0;
   end

   AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(underrun_o) |-> $past(sample_valid_o && sample_ready_i && sample_data_o == '0)); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underrun_o && !clr_underrun_i |=> underrun_o); // R7
   AST_ONE_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rready_o && !(rvalid_i && rlast_i) |=> !arvalid_o); // R4
endmodule

// File: tb/ring_stream_dma_tb.sv
module ring_stream_dma_tb;
   localparam int DW = 16, IW = 12, MAXB = 4, DEPTH = 8;
   localparam logic [31:0] BASE = 32'h1000_0040;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_ni = 1'b0, enable_i = 1'b0, clr_i = 1'b0;
   logic [31:0]   base_i = BASE;
   logic [IW-1:0] size_i = '0, wr_ptr_i = '0;
   logic          arready_i = 1'b0, rvalid_i = 1'b0, rlast_i = 1'b0, sample_ready_i = 1'b0;
   logic [DW-1:0] rdata_i = '0;
   logic          arvalid_o, rready_o, sample_valid_o, underrun_o, irq_o;
   logic [31:0]   araddr_o;
   logic [7:0]    arlen_o;
   logic [2:0]    arsize_o;
   logic [1:0]    arburst_o;
   logic [DW-1:0] sample_data_o;

   ring_stream_dma u_dut (
      .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .base_i(base_i),
      .size_i(size_i), .wr_ptr_i(wr_ptr_i), .clr_underrun_i(clr_i),
      .arvalid_o(arvalid_o), .arready_i(arready_i), .araddr_o(araddr_o),
      .arlen_o(arlen_o), .arsize_o(arsize_o), .arburst_o(arburst_o),
      .rvalid_i(rvalid_i), .rready_o(rready_o), .rdata_i(rdata_i), .rlast_i(rlast_i),
      .sample_valid_o(sample_valid_o), .sample_ready_i(sample_ready_i),
      .sample_data_o(sample_data_o), .underrun_o(underrun_o), .irq_o(irq_o)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 1'b0;
   // stimulus controls, copied onto the pins only in the drive step
   bit g_rst = 0, g_en = 0, g_clr = 0;
   int g_size = 22, g_wr = 0, g_rdy = 1;
   // memory responder
   logic [31:0] p_addr = '0;
   int p_left = 0;
   // reference model
   int m_st = 0, m_rd = 0, m_blen = 0;
   logic [DW-1:0] m_q[$];
   bit m_flag = 0;

   function automatic logic [DW-1:0] mem_word(logic [31:0] a);
      return a[16:1] ^ 16'h3C5A;
   endfunction

   task automatic chk(string tag, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
      end
   endtask

   task automatic step();
      int avail, len;
      bit starved, can_issue, pop, push;
      string t;
      @(negedge clk);
      rst_ni   = g_rst;
      enable_i = g_en;
      size_i   = IW'(g_size);
      wr_ptr_i = IW'(g_wr);
      clr_i    = g_clr;
      g_clr    = 0;
      arready_i = (cyc % 3 != 0);
      rvalid_i  = (p_left > 0) && (cyc % 5 != 2);
      rdata_i   = mem_word(p_addr);
      rlast_i   = (p_left == 1);
      sample_ready_i = (g_rdy == 1) || (g_rdy == 2 && cyc % 2 == 0);
      #1;
      if (!rst_ni) begin
         m_st = 0; m_rd = 0; m_blen = 0; m_q.delete(); m_flag = 0; p_left = 0;
      end
      avail   = (g_wr >= m_rd) ? g_wr - m_rd : g_wr + g_size - m_rd;
      len     = (g_size - m_rd < MAXB) ? g_size - m_rd : MAXB;
      starved = g_en && m_q.size() == 0 && m_st == 0 && avail < len;
      can_issue = g_en && m_st == 0 && m_q.size() + MAXB <= DEPTH && avail >= len && len > 0;
      t = !rst_ni ? "R9" : (!g_en ? "R10" : "");
      chk(t != "" ? t : "R3", "arvalid", arvalid_o, m_st == 1);
      if (m_st == 1) begin
         chk("R1", "araddr", araddr_o, BASE + 32'(m_rd * 2));
         chk("R2", "arlen", arlen_o, m_blen - 1);
         chk("R2", "arsize", arsize_o, 1);
         chk("R2", "arburst", arburst_o, 1);
      end
      chk(t != "" ? t : "R4", "rready", rready_o, m_st == 2);
      chk(t != "" ? t : "R6", "sample_valid", sample_valid_o, m_q.size() > 0 || starved);
      if (sample_valid_o)
         chk(m_q.size() > 0 ? "R5" : "R6", "sample_data", sample_data_o,
             m_q.size() > 0 ? m_q[0] : 0);
      chk(t != "" ? t : "R7", "underrun", underrun_o, m_flag);
      chk(t != "" ? t : "R8", "irq", irq_o, m_flag);
      if (rst_ni) begin
         if (arvalid_o && arready_i) begin p_addr = araddr_o; p_left = int'(arlen_o) + 1; end
         else if (rvalid_i && rready_o) begin p_addr += 2; p_left--; end
         pop  = m_q.size() > 0 && sample_ready_i;
         push = m_st == 2 && rvalid_i;
         if (starved && sample_ready_i) m_flag = 1;
         else if (clr_i)                m_flag = 0;
         if (pop)  void'(m_q.pop_front());
         if (push) m_q.push_back(rdata_i);
         case (m_st)
            0: if (can_issue) begin m_st = 1; m_blen = len; end
               else if (!g_en) m_rd = 0;
            1: if (arready_i) begin
                  m_st = 2; m_rd += m_blen;
                  if (m_rd >= g_size) m_rd = 0;
               end
            default: if (rvalid_i && rlast_i) m_st = 0;
         endcase
      end
      cyc++;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      run(4);                                   // R9 reset state
      g_rst = 1; run(3);                        // R10 disabled: no fetch, no zero fill
      g_en = 1; run(4);                         // R6 R7 R8 starvation with sink ready
      g_rdy = 0; g_clr = 1; run(3);             // R7 clear while sink stalled
      g_rdy = 2; g_wr = 10; run(40);            // R1 R3 R5 streaming
      g_wr = 21; run(40);
      g_wr = 7;  run(60);                       // R1 wrap of write index
      g_rdy = 0; g_wr = 20; run(40);            // R3 FIFO full holds bursts back
      g_rdy = 1; run(60);
      g_en = 0; run(30);                        // R10 index returns to 0
      g_size = 6; g_wr = 5; run(3);
      g_en = 1; g_rdy = 2; run(40);             // R2 shortened burst at wrap
      g_wr = 3; run(40);
      g_wr = 5; run(40);
      g_clr = 1; run(6);                        // R7 clear while starved and ready
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R5 watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule